// File: doc/BRIEF.md
# Master Register Bank Sequencer

This block is the master end of a half-duplex parallel link to a slave board that digitises analog inputs and drives analog outputs. It keeps eight 16-bit registers: four for analog channels and four for digital input/output words. Every write to the bank goes through one path. A 2-bit load-source code selects the write data, and an address decoder enables at most one register. Registers outside a parameter-defined active map cannot be written.

A built-in sequencer runs a fixed exchange over the handshake wires. It acquires a word from analog channel address 0 into register 0, pauses, and sends that word back out to output channel 1. It pauses again, acquires channel address 1 into register 1, pauses, and then keeps sending register 1 to output channel 1 until stopped. Before each send it suspends acquisition and waits for the slave's acknowledge. It drives the shared bus only after that handshake has finished. Both handshake inputs from the slave pass through a two-flop synchronizer. An external port can also write and read the bank, and the sequencer's own writes take priority over it.

Top module: `mreg_seq_top`

## Requirements
- R1: After synchronous reset all registers read 0, and acq_req, rts, bc_req, bus_oe, tx_led and bus_out are 0.
- R2: An external write (ext_we high for one cycle) updates only the register at ext_addr, on the next clock edge. rd_data shows the register at rd_addr one cycle after rd_addr is applied.
- R3: The load-source code selects the write data: 0 = bus_in word, 1 = ext_din, 2 = copy of the register at rd_addr, 3 = clear to zero.
- R4: A write to an address whose bit in ACTIVE_MASK is 0 is ignored. The default mask enables addresses 0 to 6, so address 7 always reads 0.
- R5: During an acquisition, acq_req is high and acq_ch names the channel. On the first cycle the synchronized s_valid is seen rising, bus_in is stored into the register whose address equals acq_ch. acq_req then stays high for ACQ_CYC further cycles.
- R6: Before a send, rts rises while bc_req is low. bc_req rises only after the synchronized s_ack has gone high.
- R7: bus_oe and tx_led rise only after the synchronized s_ack has returned low. While bus_oe is high, bus_out carries the selected register, out_ch is 1 and acq_req is low.
- R8: The sequence order is: acquire address 0; gap; send register 0 for BC_CYC cycles; gap; acquire address 1; gap; send register 1 until stopped. Each gap lasts GAP_CYC cycles with acq_req and rts both low.
- R9: When a sequencer store and an external write fall in the same cycle, the sequencer store is kept and the external write is dropped.
- R10: stop returns the sequencer to idle on the next edge, which releases the bus and drops acq_req, rts and bc_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the test sequence |
| stop | input | 1 | Abort or end the sequence |
| s_valid | input | 1 | Slave: sampled word on bus_in is stable |
| s_ack | input | 1 | Slave: suspend/send acknowledge |
| bus_in | input | 16 | Word received from the slave |
| acq_req | output | 1 | Acquisition request |
| acq_ch | output | 3 | Channel address being acquired |
| rts | output | 1 | Suspend acquisition / send pending |
| bc_req | output | 1 | Send request |
| out_ch | output | 3 | Output channel addressed by a send |
| bus_oe | output | 1 | Tri-state enable for bus_out |
| bus_out | output | 16 | Word driven to the slave |
| tx_led | output | 1 | Transmit indicator |
| ext_we | input | 1 | External write enable |
| ext_addr | input | 3 | External write address |
| ext_sel | input | 2 | External load-source code |
| ext_din | input | 16 | Digital input word |
| rd_addr | input | 3 | Read address, also copy source |
| rd_data | output | 16 | Registered read data |

## Verification
The sequencer's store of an acquired word and an external write can land on the bank in the same clock. The bench provokes this by timing its slave model. It raises s_valid, counts the two synchronizer stages, and pulses an external write of 0xDEAD to register 0 in exactly the cycle the sequencer stores 0x0AAA. The result is judged at the ports: register 0 must read back 0x0AAA, and the first send must carry that same word.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  typedef enum logic [1:0] {
    LD_BUS  = 2'd0,
    LD_DIN  = 2'd1,
    LD_COPY = 2'd2,
    LD_CLR  = 2'd3
  } ld_src_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACQ,
    S_HOLD,
    S_GAP,
    S_SUSP,
    S_BREQ,
    S_DRIVE
  } seq_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/mreg_sync2.sv
module mreg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/mreg_bank.sv
module mreg_bank
  import mreg_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          NREG        = 8,
  parameter logic [NREG-1:0] ACTIVE_MASK = 8'h7F,
  localparam int         AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] bus_word,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] bc_addr,
  output logic [DW-1:0] bc_word
);
  logic [DW-1:0]   regs [NREG];
  logic [NREG-1:0] wr_en;
  logic [DW-1:0]   wdata;

  // address decoder, gated by the active channel map
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_en[i] = we && (addr == AW'(i)) && ACTIVE_MASK[i];
  end

  // load source multiplexer
  always_comb begin
    case (ld_src_e'(sel))
      LD_BUS:  wdata = bus_word;
      LD_DIN:  wdata = din;
      LD_COPY: wdata = regs[rd_addr];
      default: wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rd_data <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en[i]) regs[i] <= wdata;
      rd_data <= regs[rd_addr];
    end
  end

  assign bc_word = regs[bc_addr];

  // R2: never more than one register enabled
  p_onehot_wr_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R4: registers outside the active map never change
  for (genvar i = 0; i < NREG; i++) begin : g_chk
    if (!ACTIVE_MASK[i]) begin : g_inactive
      p_inactive_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[i]));
    end
  end
endmodule

// File: rtl/mreg_seq.sv
module mreg_seq
  import mreg_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int ACQ_CYC = 4,
  parameter int GAP_CYC = 3,
  parameter int BC_CYC  = 6,
  parameter int CH_A    = 0,
  parameter int CH_B    = 1,
  parameter int OUT_CH  = 1,
  localparam int CW     = $clog2(max3(ACQ_CYC, GAP_CYC, BC_CYC) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          valid_s,
  input  logic          ack_s,
  input  logic [DW-1:0] bc_word,
  output logic          seq_we,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] bc_addr,
  output logic          acq_req,
  output logic [AW-1:0] acq_ch,
  output logic          rts,
  output logic          bc_req,
  output logic [AW-1:0] out_ch,
  output logic          bus_oe,
  output logic          tx_led,
  output logic [DW-1:0] bus_out
);
  seq_st_e       state, nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          round, round_nxt;
  logic          after_bc, after_bc_nxt;
  logic          valid_q;
  logic          valid_rise;

  assign valid_rise = valid_s && !valid_q;
  assign seq_addr   = round ? AW'(CH_B) : AW'(CH_A);
  assign bc_addr    = seq_addr;
  assign seq_we     = (state == S_ACQ) && valid_rise;

  always_comb begin
    nxt          = state;
    cnt_nxt      = cnt;
    round_nxt    = round;
    after_bc_nxt = after_bc;
    if (cnt != '0) cnt_nxt = cnt - 1'b1;
    case (state)
      S_IDLE: if (start) begin
        nxt       = S_ACQ;
        round_nxt = 1'b0;
      end
      S_ACQ: if (valid_rise) begin
        nxt     = S_HOLD;
        cnt_nxt = CW'(ACQ_CYC - 1);
      end
      S_HOLD: if (cnt == '0) begin
        nxt          = S_GAP;
        cnt_nxt      = CW'(GAP_CYC - 1);
        after_bc_nxt = 1'b0;
      end
      S_GAP: if (cnt == '0) begin
        if (after_bc) begin
          nxt       = S_ACQ;
          round_nxt = 1'b1;
        end else begin
          nxt = S_SUSP;
        end
      end
      S_SUSP: if (ack_s) nxt = S_BREQ;
      S_BREQ: if (!ack_s) begin
        nxt     = S_DRIVE;
        cnt_nxt = CW'(BC_CYC - 1);
      end
      S_DRIVE: if (!round && cnt == '0) begin
        nxt          = S_GAP;
        cnt_nxt      = CW'(GAP_CYC - 1);
        after_bc_nxt = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
    if (stop && state != S_IDLE) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      round    <= 1'b0;
      after_bc <= 1'b0;
      valid_q  <= 1'b0;
      acq_req  <= 1'b0;
      acq_ch   <= '0;
      rts      <= 1'b0;
      bc_req   <= 1'b0;
      out_ch   <= '0;
      bus_oe   <= 1'b0;
      tx_led   <= 1'b0;
      bus_out  <= '0;
    end else begin
      state    <= nxt;
      cnt      <= cnt_nxt;
      round    <= round_nxt;
      after_bc <= after_bc_nxt;
      valid_q  <= valid_s;
      acq_req  <= (nxt == S_ACQ) || (nxt == S_HOLD);
      acq_ch   <= ((nxt == S_ACQ) || (nxt == S_HOLD))
                  ? (round_nxt ? AW'(CH_B) : AW'(CH_A)) : '0;
      rts      <= (nxt == S_SUSP) || (nxt == S_BREQ) || (nxt == S_DRIVE);
      bc_req   <= (nxt == S_BREQ) || (nxt == S_DRIVE);
      out_ch   <= ((nxt == S_BREQ) || (nxt == S_DRIVE)) ? AW'(OUT_CH) : '0;
      bus_oe   <= (nxt == S_DRIVE);
      tx_led   <= (nxt == S_DRIVE);
      bus_out  <= (nxt == S_DRIVE) ? bc_word : '0;
    end
  end

  // R6: send request only rises while suspension is already raised
  p_rts_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bc_req) |-> $past(rts));

  // R7: bus driven only after the acknowledge returned low
  p_drive_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> !$past(ack_s));

  // R7: no acquisition while the bus is driven
  p_acq_off_bus_r7: assert property (@(posedge clk) disable iff (rst)
    acq_req |-> !bus_oe);

  // R8: gaps are quiet on the handshake wires
  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> (!acq_req && !rts));
endmodule

// File: rtl/mreg_seq_top.sv
module mreg_seq_top
  import mreg_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          NREG        = 8,
  parameter logic [NREG-1:0] ACTIVE_MASK = 8'h7F,
  parameter int          ACQ_CYC     = 4,
  parameter int          GAP_CYC     = 3,
  parameter int          BC_CYC      = 6,
  parameter int          CH_A        = 0,
  parameter int          CH_B        = 1,
  parameter int          OUT_CH      = 1,
  localparam int         AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          s_valid,
  input  logic          s_ack,
  input  logic [DW-1:0] bus_in,
  output logic          acq_req,
  output logic [AW-1:0] acq_ch,
  output logic          rts,
  output logic          bc_req,
  output logic [AW-1:0] out_ch,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  output logic          tx_led,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [1:0]    ext_sel,
  input  logic [DW-1:0] ext_din,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [1:0]    hs_sync;
  logic          seq_we;
  logic [AW-1:0] seq_addr, bc_addr;
  logic [DW-1:0] bc_word;
  logic          bank_we;
  logic [AW-1:0] bank_addr;
  logic [1:0]    bank_sel;

  mreg_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({s_ack, s_valid}),
    .q   (hs_sync)
  );

  // sequencer store has priority over the external port
  assign bank_we   = seq_we || ext_we;
  assign bank_addr = seq_we ? seq_addr : ext_addr;
  assign bank_sel  = seq_we ? 2'(LD_BUS) : ext_sel;

  mreg_bank #(
    .DW          (DW),
    .NREG        (NREG),
    .ACTIVE_MASK (ACTIVE_MASK)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (bank_we),
    .addr     (bank_addr),
    .sel      (bank_sel),
    .bus_word (bus_in),
    .din      (ext_din),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .bc_addr  (bc_addr),
    .bc_word  (bc_word)
  );

  mreg_seq #(
    .DW      (DW),
    .AW      (AW),
    .ACQ_CYC (ACQ_CYC),
    .GAP_CYC (GAP_CYC),
    .BC_CYC  (BC_CYC),
    .CH_A    (CH_A),
    .CH_B    (CH_B),
    .OUT_CH  (OUT_CH)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (stop),
    .valid_s  (hs_sync[0]),
    .ack_s    (hs_sync[1]),
    .bc_word  (bc_word),
    .seq_we   (seq_we),
    .seq_addr (seq_addr),
    .bc_addr  (bc_addr),
    .acq_req  (acq_req),
    .acq_ch   (acq_ch),
    .rts      (rts),
    .bc_req   (bc_req),
    .out_ch   (out_ch),
    .bus_oe   (bus_oe),
    .tx_led   (tx_led),
    .bus_out  (bus_out)
  );

  // R9: an acquired store never coincides with an external-port address win
  p_seq_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_we && ext_we) |-> (bank_sel == 2'(LD_BUS)));
endmodule

// File: tb/tb_mreg_seq_top.sv
module tb_mreg_seq_top;
  localparam int ACQ_CYC = 4;
  localparam int GAP_CYC = 3;
  localparam int BC_CYC  = 6;
  localparam logic [15:0] W_CH0 = 16'h0AAA;
  localparam logic [15:0] W_CH1 = 16'h0BBB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, stop = 1'b0;
  logic        s_valid = 1'b0, s_ack = 1'b0;
  logic [15:0] bus_in = '0;
  logic        acq_req, rts, bc_req, bus_oe, tx_led;
  logic [2:0]  acq_ch, out_ch;
  logic [15:0] bus_out, rd_data;
  logic        ext_we = 1'b0;
  logic [2:0]  ext_addr = '0;
  logic [1:0]  ext_sel = '0;
  logic [15:0] ext_din = '0;
  logic [2:0]  rd_addr = '0;

  int n_chk = 0, n_bad = 0;
  logic collide_en = 1'b0;
  logic acked = 1'b0;
  int   lat = 0, k = 0;

  always #2.5 clk = ~clk;

  mreg_seq_top #(.ACQ_CYC(ACQ_CYC), .GAP_CYC(GAP_CYC), .BC_CYC(BC_CYC)) dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .s_valid(s_valid), .s_ack(s_ack), .bus_in(bus_in),
    .acq_req(acq_req), .acq_ch(acq_ch), .rts(rts), .bc_req(bc_req),
    .out_ch(out_ch), .bus_oe(bus_oe), .bus_out(bus_out), .tx_led(tx_led),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_sel(ext_sel),
    .ext_din(ext_din), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // slave model
  always @(negedge clk) begin
    if (rst) begin
      s_valid <= 1'b0; s_ack <= 1'b0; acked <= 1'b0; lat <= 0; k <= 0;
    end else begin
      if (acq_req) begin
        if (!s_valid) begin
          if (lat == 2) begin
            bus_in  <= (acq_ch == 3'd0) ? W_CH0 : W_CH1;
            s_valid <= 1'b1;
            lat     <= 0;
            k       <= 1;
          end else lat <= lat + 1;
        end
      end else begin
        s_valid <= 1'b0;
        lat     <= 0;
      end
      if (collide_en && k != 0) begin
        k <= k + 1;
        if (k == 2) begin
          ext_we <= 1'b1; ext_addr <= 3'd0; ext_sel <= 2'd1; ext_din <= 16'hDEAD;
        end
        if (k == 3) begin
          ext_we <= 1'b0; collide_en <= 1'b0; k <= 0;
        end
      end else if (!collide_en) k <= 0;
      if (!rts) begin
        s_ack <= 1'b0; acked <= 1'b0;
      end else if (bc_req) begin
        s_ack <= 1'b0; acked <= 1'b1;
      end else if (!acked) s_ack <= 1'b1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic ext_write(input logic [2:0] a, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_addr = a; ext_sel = s; ext_din = d;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 acq_req", 32'(acq_req), 0);
    chk("R1 rts/bc_req", 32'({rts, bc_req}), 0);
    chk("R1 bus_oe/tx_led", 32'({bus_oe, tx_led}), 0);
    chk("R1 bus_out", 32'(bus_out), 0);
    rd(3'd0, v); chk("R1 reg0", 32'(v), 0);
    rd(3'd6, v); chk("R1 reg6", 32'(v), 0);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    ext_write(3'd4, 2'd1, 16'h1234);
    rd(3'd4, v); chk("R2 din write reg4", 32'(v), 32'h1234);
    rd(3'd3, v); chk("R2 neighbour reg3 untouched", 32'(v), 0);
    rd_addr = 3'd4;
    ext_write(3'd5, 2'd2, 16'hFFFF);
    rd(3'd5, v); chk("R3 copy reg4->reg5", 32'(v), 32'h1234);
    ext_write(3'd4, 2'd3, 16'hFFFF);
    rd(3'd4, v); chk("R3 clear reg4", 32'(v), 0);
    bus_in = 16'h5A5A;
    ext_write(3'd6, 2'd0, 16'h0000);
    rd(3'd6, v); chk("R3 bus source reg6", 32'(v), 32'h5A5A);
  endtask

  task automatic t_inactive();
    logic [15:0] v;
    ext_write(3'd7, 2'd1, 16'hFFFF);
    rd(3'd7, v); chk("R4 inactive reg7 ignored", 32'(v), 0);
    rd(3'd6, v); chk("R4 reg6 unchanged", 32'(v), 32'h5A5A);
  endtask

  task automatic t_sequence();
    logic [15:0] v;
    int n;
    int bad;
    collide_en = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R5 first acq_req", 32'(acq_req), 1);
    chk("R8 first channel address 0", 32'(acq_ch), 0);
    while (acq_req) @(negedge clk);
    n = 0;
    while (!rts) begin n++; @(negedge clk); end
    chk("R8 gap length", 32'(n), 32'(GAP_CYC));
    chk("R6 rts before bc_req", 32'(bc_req), 0);
    while (!bus_oe) @(negedge clk);
    chk("R7 ack low when driving", 32'(s_ack), 0);
    chk("R7 out_ch", 32'(out_ch), 1);
    chk("R7 tx_led", 32'(tx_led), 1);
    chk("R9 first send carries acquired word", 32'(bus_out), 32'(W_CH0));
    n = 0;
    while (bus_oe) begin n++; @(negedge clk); end
    chk("R8 first send length", 32'(n), 32'(BC_CYC));
    while (!acq_req) @(negedge clk);
    chk("R8 second channel address 1", 32'(acq_ch), 1);
    while (!bus_oe) @(negedge clk);
    bad = 0;
    repeat (20) begin
      if (bus_out !== W_CH1 || !bus_oe || acq_req) bad++;
      @(negedge clk);
    end
    chk("R8 final send holds reg1", 32'(bad), 0);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R10 bus released", 32'({bus_oe, tx_led}), 0);
    chk("R10 handshake dropped", 32'({rts, bc_req}), 0);
    rd(3'd0, v); chk("R9 reg0 keeps sequencer word", 32'(v), 32'(W_CH0));
    rd(3'd1, v); chk("R5 reg1 holds channel 1 word", 32'(v), 32'(W_CH1));
  endtask

  task automatic t_early_stop();
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!s_valid) @(negedge clk);
    n = 0;
    while (acq_req) begin n++; @(negedge clk); end
    // valid -> 2 sync stages -> store edge -> ACQ_CYC hold cycles
    chk("R5 acq_req hold after valid", 32'(n), 32'(2 + ACQ_CYC));
    while (!rts) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R10 stop during suspend", 32'({rts, bc_req, bus_oe}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ext();
    t_inactive();
    t_sequence();
    t_early_stop();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule